// File: doc/BRIEF.md
# Hardwired Instruction Phase Sequencer

This block is the control sequencer of a small accumulator machine. It holds a phase counter and combines it with the opcode currently held in the instruction register. From these two values it produces the control strobes for the datapath: the drivers and loads of a shared internal bus, the memory address and memory data registers, the program counter, the instruction register, the accumulator and the ALU. The strobes come from fixed decode logic. No control store is involved.

Every instruction starts with the same three fetch phases. An execute sequence follows, and it depends on the opcode. A load from memory into the accumulator ends in phase 5. An add of a memory word to the accumulator needs one more phase and ends in phase 6. Any other opcode ends in phase 3 and does nothing. When the strobe that marks the end of an instruction is raised, the phase counter returns to zero on the next clock. The datapath registers and the memory timing are not part of this block.

Top module: `hw_ctrl_seq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `phase` becomes 0 after that edge. The strobes always reflect the current `phase` and `opcode`, including during reset.
- R2: In phase 0, exactly `drv_pc`, `ld_mar` and `inc_pc` are high.
- R3: In phase 1, only `mem_rd` is high.
- R4: In phase 2, exactly `drv_mdr` and `ld_ir` are high.
- R5: In phase 3, with opcode 2'b01 (load) or 2'b10 (add), exactly `drv_addr` and `ld_mar` are high.
- R6: In phase 4, with opcode 2'b01 or 2'b10, only `mem_rd` is high.
- R7: In phase 5, with opcode 2'b01, exactly `drv_mdr`, `ld_acc` and `seq_done` are high.
- R8: With opcode 2'b10, phase 5 raises only `alu_add`. Phase 6 then raises exactly `drv_res`, `ld_acc` and `seq_done`.
- R9: `phase` is a 3-bit binary count. It rises by one on every clock. On the clock after a cycle with `seq_done` high, it returns to 0.
- R10: In phase 3, with opcode 2'b00 or 2'b11, only `seq_done` is high, so the instruction has no effect.
- R11: In every cycle, at most one of the bus drivers `drv_pc`, `drv_mdr`, `drv_addr` and `drv_res` is high.
- R12: The strobes of phases 0 to 2 do not depend on `opcode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low; clears the phase counter |
| opcode | input | 2 | Opcode from the instruction register (01 load, 10 add) |
| phase | output | 3 | Current phase count |
| drv_pc | output | 1 | Program counter drives the internal bus |
| ld_mar | output | 1 | Memory address register loads from the bus |
| inc_pc | output | 1 | Program counter increments |
| mem_rd | output | 1 | Memory read request |
| drv_mdr | output | 1 | Memory data register drives the bus |
| ld_ir | output | 1 | Instruction register loads from the bus |
| drv_addr | output | 1 | Address field of the instruction drives the bus |
| ld_acc | output | 1 | Accumulator path loads from the bus |
| alu_add | output | 1 | ALU performs an add into its result register |
| drv_res | output | 1 | ALU result register drives the bus |
| seq_done | output | 1 | Last phase of the instruction; the counter clears next |

## Verification
The strobes are combinational in `phase` and `opcode`, so they are due in the same cycle the inputs settle. `phase` changes one register stage after each rising edge. The driver changes `opcode` and `rst_n` on the falling edge and queues the expected strobes and phase for that cycle. The monitor samples one nanosecond later, before the next rising edge, so every comparison sees a settled cycle. During fetch the driver changes `opcode` in every cycle. A reset is also raised partway through an add, and the check expects phase 0 one edge later.

// File: rtl/ctl_seq_pkg.sv
// Package: shared types and constants for the hardwired phase sequencer.
// Assumes a 2-bit opcode and a fixed three-phase fetch shared by all opcodes.
package ctl_seq_pkg;

    localparam int OP_W      = 2;
    localparam int FETCH_LEN = 3;

    typedef logic [OP_W-1:0] opc_t;

    localparam opc_t OPC_LOAD = 2'b01;
    localparam opc_t OPC_ADD  = 2'b10;

    // One bit per datapath control line
    typedef struct packed {
        logic drv_pc;
        logic ld_mar;
        logic inc_pc;
        logic mem_rd;
        logic drv_mdr;
        logic ld_ir;
        logic drv_addr;
        logic ld_acc;
        logic alu_add;
        logic drv_res;
        logic seq_done;
    } strobe_t;

    localparam strobe_t STROBE_NONE = '0;

    // Bitwise OR of two strobe sets
    function automatic strobe_t strobe_or(strobe_t a, strobe_t b);
        return strobe_t'(a | b);
    endfunction

endpackage

// File: rtl/ctl_step_ctr.sv
// Phase counter: counts up by one per clock and returns to zero when the
// current instruction signals completion or on synchronous active-low reset.
// Assumes the completion signal is combinational from the current count.
module ctl_step_ctr #(
    parameter int STEP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    output logic [STEP_W-1:0] step
);

    // Advance the phase, or restart it at an instruction boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step <= '0;
        end else if (clear) begin
            step <= '0;
        end else begin
            step <= step + 1'b1;
        end
    end

endmodule

// File: rtl/ctl_fetch_dec.sv
// Fetch decoder: strobes for the common fetch phases. These do not depend on
// the opcode. Assumes the fetch occupies phases 0 to FETCH_LEN-1.
module ctl_fetch_dec
    import ctl_seq_pkg::*;
#(
    parameter int STEP_W = 3
) (
    input  logic [STEP_W-1:0] step,
    output logic              in_fetch,
    output strobe_t           fetch_s
);

    localparam logic [STEP_W-1:0] PH_ADDR = STEP_W'(0);
    localparam logic [STEP_W-1:0] PH_READ = STEP_W'(1);
    localparam logic [STEP_W-1:0] PH_LDIR = STEP_W'(2);

    // Flag the fetch window
    always_comb begin
        in_fetch = (step < STEP_W'(FETCH_LEN));
    end

    // Per-phase fetch strobes
    always_comb begin
        fetch_s = STROBE_NONE;
        unique case (step)
            PH_ADDR: begin
                fetch_s.drv_pc = 1'b1;
                fetch_s.ld_mar = 1'b1;
                fetch_s.inc_pc = 1'b1;
            end
            PH_READ: begin
                fetch_s.mem_rd = 1'b1;
            end
            PH_LDIR: begin
                fetch_s.drv_mdr = 1'b1;
                fetch_s.ld_ir   = 1'b1;
            end
            default: fetch_s = STROBE_NONE;
        endcase
    end

endmodule

// File: rtl/ctl_exec_dec.sv
// Execute decoder for one memory-operand instruction. The parameter ACCUM_ADD
// selects the variant: 0 loads the memory word into the accumulator, 1 adds it
// through the ALU, which takes one more phase. Assumes the caller gives the
// phase relative to the end of fetch. Unreachable phases end the instruction.
module ctl_exec_dec
    import ctl_seq_pkg::*;
#(
    parameter int STEP_W    = 3,
    parameter bit ACCUM_ADD = 1'b0
) (
    input  logic [STEP_W-1:0] rel_step,
    output strobe_t           exec_s
);

    localparam logic [STEP_W-1:0] E_ADDR = STEP_W'(0);
    localparam logic [STEP_W-1:0] E_READ = STEP_W'(1);
    localparam logic [STEP_W-1:0] E_OPER = STEP_W'(2);
    localparam logic [STEP_W-1:0] E_WBCK = STEP_W'(3);

    // Operand address and read phases are the same for both variants
    strobe_t common_s;
    strobe_t tail_s;

    // Shared operand phases
    always_comb begin
        common_s = STROBE_NONE;
        if (rel_step == E_ADDR) begin
            common_s.drv_addr = 1'b1;
            common_s.ld_mar   = 1'b1;
        end else if (rel_step == E_READ) begin
            common_s.mem_rd = 1'b1;
        end
    end

    generate
        if (ACCUM_ADD) begin : g_add
            // Add variant: ALU phase, then write the result back
            always_comb begin
                tail_s = STROBE_NONE;
                if (rel_step == E_OPER) begin
                    tail_s.alu_add = 1'b1;
                end else if (rel_step == E_WBCK) begin
                    tail_s.drv_res  = 1'b1;
                    tail_s.ld_acc   = 1'b1;
                    tail_s.seq_done = 1'b1;
                end else if (rel_step > E_WBCK) begin
                    tail_s.seq_done = 1'b1;
                end
            end
        end else begin : g_load
            // Load variant: move memory data straight to the accumulator
            always_comb begin
                tail_s = STROBE_NONE;
                if (rel_step == E_OPER) begin
                    tail_s.drv_mdr  = 1'b1;
                    tail_s.ld_acc   = 1'b1;
                    tail_s.seq_done = 1'b1;
                end else if (rel_step > E_OPER) begin
                    tail_s.seq_done = 1'b1;
                end
            end
        end
    endgenerate

    // Merge the shared and variant strobes
    always_comb begin
        exec_s = strobe_or(common_s, tail_s);
    end

endmodule

// File: rtl/hw_ctrl_seq.sv
// Top of the hardwired sequencer. It combines the phase counter, the fetch
// decoder and the two execute decoders, and selects the execute strobes by
// opcode. Outputs depend only on the phase and the opcode. Assumes the opcode
// input is stable from phase 3 until the instruction completes.
module hw_ctrl_seq
    import ctl_seq_pkg::*;
#(
    parameter int STEP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        opcode,
    output logic [STEP_W-1:0] phase,
    output logic              drv_pc,
    output logic              ld_mar,
    output logic              inc_pc,
    output logic              mem_rd,
    output logic              drv_mdr,
    output logic              ld_ir,
    output logic              drv_addr,
    output logic              ld_acc,
    output logic              alu_add,
    output logic              drv_res,
    output logic              seq_done
);

    localparam logic [STEP_W-1:0] EXEC_BASE = STEP_W'(FETCH_LEN);

    logic [STEP_W-1:0] step;
    logic [STEP_W-1:0] rel_step;
    logic              in_fetch;
    strobe_t           fetch_s;
    strobe_t           load_s;
    strobe_t           add_s;
    strobe_t           out_s;

    ctl_step_ctr #(.STEP_W(STEP_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (out_s.seq_done),
        .step  (step)
    );

    ctl_fetch_dec #(.STEP_W(STEP_W)) u_fetch (
        .step     (step),
        .in_fetch (in_fetch),
        .fetch_s  (fetch_s)
    );

    // Phase measured from the first execute phase
    always_comb begin
        rel_step = step - EXEC_BASE;
    end

    ctl_exec_dec #(.STEP_W(STEP_W), .ACCUM_ADD(1'b0)) u_load (
        .rel_step (rel_step),
        .exec_s   (load_s)
    );

    ctl_exec_dec #(.STEP_W(STEP_W), .ACCUM_ADD(1'b1)) u_add (
        .rel_step (rel_step),
        .exec_s   (add_s)
    );

    // Select fetch or execute strobes; unknown opcodes end at once
    always_comb begin
        out_s = STROBE_NONE;
        if (in_fetch) begin
            out_s = fetch_s;
        end else begin
            case (opc_t'(opcode))
                OPC_LOAD: out_s = load_s;
                OPC_ADD:  out_s = add_s;
                default:  out_s.seq_done = 1'b1;
            endcase
        end
    end

    // Drive the ports
    always_comb begin
        phase    = step;
        drv_pc   = out_s.drv_pc;
        ld_mar   = out_s.ld_mar;
        inc_pc   = out_s.inc_pc;
        mem_rd   = out_s.mem_rd;
        drv_mdr  = out_s.drv_mdr;
        ld_ir    = out_s.ld_ir;
        drv_addr = out_s.drv_addr;
        ld_acc   = out_s.ld_acc;
        alu_add  = out_s.alu_add;
        drv_res  = out_s.drv_res;
        seq_done = out_s.seq_done;
    end

endmodule

// File: rtl/ctl_seq_chk.sv
// Checker for the sequencer, attached to the top through bind. It relates
// the phase counter to the completion strobe and the opcode over time.
module ctl_seq_chk #(
    parameter int STEP_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        opcode,
    input logic [STEP_W-1:0] phase,
    input logic              drv_pc,
    input logic              ld_mar,
    input logic              inc_pc,
    input logic              mem_rd,
    input logic              drv_mdr,
    input logic              drv_addr,
    input logic              ld_acc,
    input logic              alu_add,
    input logic              drv_res,
    input logic              seq_done
);

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> phase == '0);

    assert_fetch_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        phase == '0 |-> drv_pc && ld_mar && inc_pc && !mem_rd && !seq_done);

    assert_load_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == STEP_W'(5) && opcode == 2'b01) |-> seq_done && ld_acc && drv_mdr);

    assert_add_longer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == STEP_W'(5) && opcode == 2'b10) |-> alu_add && !seq_done && !ld_acc);

    assert_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> phase == '0);

    assert_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_done |=> phase == STEP_W'($past(phase) + 1'b1));

    assert_unknown_nop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == STEP_W'(3) && (opcode == 2'b00 || opcode == 2'b11))
            |-> seq_done && !ld_mar && !drv_addr);

    assert_one_driver_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({drv_pc, drv_mdr, drv_addr, drv_res}) <= 1);

    assert_phase_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= STEP_W'(6));

endmodule

bind hw_ctrl_seq ctl_seq_chk #(.STEP_W(STEP_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .opcode   (opcode),
    .phase    (phase),
    .drv_pc   (drv_pc),
    .ld_mar   (ld_mar),
    .inc_pc   (inc_pc),
    .mem_rd   (mem_rd),
    .drv_mdr  (drv_mdr),
    .drv_addr (drv_addr),
    .ld_acc   (ld_acc),
    .alu_add  (alu_add),
    .drv_res  (drv_res),
    .seq_done (seq_done)
);

// File: tb/sim_hw_ctrl_seq.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues the expected strobes and phase for each
// cycle; the monitor pops and compares them 1 ns after the falling edge.
module sim_hw_ctrl_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] opcode = 2'b00;
    logic [2:0] phase;
    logic drv_pc, ld_mar, inc_pc, mem_rd, drv_mdr, ld_ir;
    logic drv_addr, ld_acc, alu_add, drv_res, seq_done;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [10:0] s;
        logic [2:0]  ph;
        string       tag;
    } item_t;

    item_t q[$];

    always #2.5 clk = ~clk;

    hw_ctrl_seq u0 (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .phase(phase),
        .drv_pc(drv_pc), .ld_mar(ld_mar), .inc_pc(inc_pc), .mem_rd(mem_rd),
        .drv_mdr(drv_mdr), .ld_ir(ld_ir), .drv_addr(drv_addr), .ld_acc(ld_acc),
        .alu_add(alu_add), .drv_res(drv_res), .seq_done(seq_done)
    );

    // Expected strobes per the requirements, order:
    // drv_pc ld_mar inc_pc mem_rd drv_mdr ld_ir drv_addr ld_acc alu_add drv_res seq_done
    function automatic logic [10:0] exp_s(logic [1:0] op, int p);
        if (p == 0) return 11'b111_0000_0000;
        if (p == 1) return 11'b000_1000_0000;
        if (p == 2) return 11'b000_0110_0000;
        if (op != 2'b01 && op != 2'b10) return 11'b000_0000_0001;
        if (p == 3) return 11'b010_0001_0000;
        if (p == 4) return 11'b000_1000_0000;
        if (op == 2'b01) return 11'b000_0100_1001;
        if (p == 5) return 11'b000_0000_0100;
        return 11'b000_0000_1011;
    endfunction

    function automatic string tag_of(logic [1:0] op, int p);
        if (p == 0) return "R2 R12";
        if (p == 1) return "R3 R12";
        if (p == 2) return "R4 R12";
        if (op != 2'b01 && op != 2'b10) return "R10";
        if (p == 3) return "R5";
        if (p == 4) return "R6";
        if (op == 2'b01) return "R7";
        return "R8";
    endfunction

    function automatic int len_of(logic [1:0] op);
        if (op == 2'b01) return 6;
        if (op == 2'b10) return 7;
        return 4;
    endfunction

    task automatic push(logic [1:0] op, int p, string tag);
        item_t it;
        it.s   = exp_s(op, p);
        it.ph  = 3'(p);
        it.tag = tag;
        q.push_back(it);
    endtask

    // Drive one instruction from phase 'first'; called at a falling edge
    task automatic run_instr(logic [1:0] op, int first);
        for (int p = first; p < len_of(op); p++) begin
            opcode = (p < 3) ? 2'((p * 3 + 1) ^ op) : op;
            push(op, p, tag_of(op, p));
            @(negedge clk);
        end
    endtask

    // Reset raised during phase 4 of an add
    task automatic mid_reset();
        run_instr_head();
        rst_n = 1'b0;
        push(2'b10, 4, "R6");
        @(negedge clk);
        rst_n = 1'b1;
        opcode = 2'b11;
        push(2'b10, 0, "R1");
        @(negedge clk);
        run_instr(2'b10, 1);
    endtask

    task automatic run_instr_head();
        for (int p = 0; p < 4; p++) begin
            opcode = (p < 3) ? 2'(p) : 2'b10;
            push(2'b10, p, tag_of(2'b10, p));
            @(negedge clk);
        end
        opcode = 2'b10;
    endtask

    // Monitor: compare settled outputs against the queue
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                logic [10:0] act;
                it  = q.pop_front();
                act = {drv_pc, ld_mar, inc_pc, mem_rd, drv_mdr, ld_ir,
                       drv_addr, ld_acc, alu_add, drv_res, seq_done};
                n_checks++;
                if (act !== it.s) begin
                    n_fail++;
                    $display("FAIL %s strobes phase %0d: actual %b expected %b",
                             it.tag, it.ph, act, it.s);
                end
                n_checks++;
                if (phase !== it.ph) begin
                    n_fail++;
                    $display("FAIL R9 phase: actual %0d expected %0d", phase, it.ph);
                end
                n_checks++;
                if ($countones({drv_pc, drv_mdr, drv_addr, drv_res}) > 1) begin
                    n_fail++;
                    $display("FAIL R11 bus drivers: actual %b expected at most one",
                             {drv_pc, drv_mdr, drv_addr, drv_res});
                end
            end
        end
    end

    // Stimulus
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        push(2'b11, 0, "R1");
        opcode = 2'b00;
        @(negedge clk);
        run_instr(2'b01, 1);
        run_instr(2'b10, 0);
        run_instr(2'b00, 0);
        run_instr(2'b01, 0);
        run_instr(2'b11, 0);
        run_instr(2'b10, 0);
        run_instr(2'b10, 0);
        mid_reset();
        run_instr(2'b01, 0);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule